// File: doc/BRIEF.md
# Streaming Matrix Transposer

The block accepts a stream of data words in row-major order. It accepts one word on every clock edge where `en` is high, and it returns the same words in column-major order at the same rate. A full matrix of `ROWS` x `COLS` words is collected in one half of an internal two-bank store. While that happens, the previous matrix is read out of the other half in transposed order. Matrices therefore follow one another with no idle cycles, and the latency from input to output is fixed.

The read addresses come from a schedule counter that runs over one full period of both banks (`2*ROWS*COLS` enabled cycles). They are decoded through a tree of multiplexers. The tree has `PIPE_DEPTH` register stages, and each stage picks one of `MUX_RADIX` inputs. The counter runs `PIPE_DEPTH` steps ahead of the data. The incoming words pass through the same number of extra register stages, plus an optional input register. Data and addresses therefore meet on the same cycle. The stream has no valid/ready handshake and no back-pressure. The source pauses the stream by holding `en` low, and the consumer must take `dout` on every enabled edge. With `en` low, nothing in the block advances.

Legal settings are as follows. Either `MUX_RADIX` = 1 with `PIPE_DEPTH` = 0, or `MUX_RADIX` is a power of two above one with `PIPE_DEPTH` >= 1 and `IN_SYNC` = 1. In both cases `MUX_RADIX**PIPE_DEPTH` must not exceed the schedule period. Any other setting stops elaboration.

Top module: `stream_transposer`

## Requirements
- R1: While `rst` is high on a clock edge, `dout` becomes 0 and the schedule restarts. The first enabled edge after reset takes input word number 0.
- R2: Let input word k (k = 0, 1, ...) be taken at the k-th enabled edge, and let N = ROWS*COLS. Output word o appears on `dout` after enabled edge o + L, where L = N + PIPE_DEPTH + IN_SYNC + 1. Output o is input word b*N + (j mod ROWS)*COLS + j div ROWS, with b = o div N and j = o mod N. Within a matrix, rows step in the inner loop and columns in the outer loop.
- R3: Consecutive matrices stream back to back with no gap. Matrix b+1 comes out directly after matrix b, and the same timing holds for any number of matrices.
- R4: On a clock edge with `en` low, `din` is ignored and `dout` keeps its value. Pauses of any length leave the output order and the latency (counted in enabled edges) unchanged.
- R5: Every legal pipeline setting gives the same output order. The output shifts later by exactly one enabled edge for each stage of address pipelining and for the input register.
- R6: Non-square shapes (for example 4 rows by 8 columns) are transposed correctly.
- R7: The write address advances by one per enabled edge, modulo 2*N, from reset on.
- R8: Once `PIPE_DEPTH` enabled edges have passed since reset, the read address always lies in the opposite bank from the write address: addresses 0..N-1 form bank 0 and N..2N-1 form bank 1. The read address never reaches 2*N or above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable; all state advances only on edges where this is high |
| din | input | WL | Data word, row-major order |
| dout | output | WL | Data word, column-major order |

## Verification
Several configurations are checked. These are square shapes from 2 to 7 with different radix and depth settings, the 2x2 case without an input register, and the rectangular 4x8 case. A wrong tree digit or a misaligned pipeline shows up as words swapped within a matrix. Wrong latency accounting shifts the whole stream by whole cycles. A mistake in the bank toggle or the counter wrap damages the second and later matrices while the first one still looks correct, so the bench runs four matrices back to back. Pauses on `en` are applied with a garbage value on `din`. A design that lets anything advance while paused slips the stream or lets the garbage value through. A reset in the middle of a stream checks that the design does not resume from an old schedule position.

// File: rtl/tmx_pkg.sv
package tmx_pkg;

  // Integer power used for parameter legality checks and tree sizing.
  function automatic int ipow(input int base, input int ex);
    int r;
    r = 1;
    for (int i = 0; i < ex; i++) r = r * base;
    return r;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // Read address used at schedule step e: the bank not being written,
  // offset by the transposed position inside the matrix.
  function automatic int rd_index(input int e, input int rows, input int cols);
    int n, bank, k;
    n    = rows * cols;
    bank = e / n;
    k    = e % n;
    return (1 - bank) * n + (k % rows) * cols + (k / rows);
  endfunction

endpackage

// File: rtl/tmx_delay.sv
module tmx_delay #(
  parameter int WL     = 16,
  parameter int STAGES = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [WL-1:0] d,
  output logic [WL-1:0] q
);

  generate
    if (STAGES == 0) begin : g_wire
      assign q = d;
    end else begin : g_chain
      logic [WL-1:0] r [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) r[i] <= '0;
        end else if (en) begin
          r[0] <= d;
          for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
        end
      end
      assign q = r[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/tmx_addr_gen.sv
module tmx_addr_gen #(
  parameter int ROWS       = 4,
  parameter int COLS       = 8,
  parameter int MUX_RADIX  = 2,
  parameter int PIPE_DEPTH = 2,
  parameter int IN_SYNC    = 1,
  localparam int NT        = 2 * ROWS * COLS,
  localparam int AW        = $clog2(NT),
  localparam int SEL       = $clog2(MUX_RADIX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr
);

  // Count stage l holds the lead counter delayed by l enabled edges.
  logic [AW-1:0] cnt_p [PIPE_DEPTH+1];
  logic [AW-1:0] tbl   [NT];

  function automatic logic [AW-1:0] cnt_reset(input int l);
    return AW'((4 * NT - IN_SYNC - l) % NT);
  endfunction

  function automatic int digit(input logic [AW-1:0] v, input int l);
    return (int'(v) >> (l * SEL)) % MUX_RADIX;
  endfunction

  function automatic int pick(input int n, input logic [AW-1:0] v, input int l);
    int idx;
    idx = n * MUX_RADIX + digit(v, l);
    return (idx < NT) ? idx : NT - 1;
  endfunction

  function automatic bit in_range(input int n, input logic [AW-1:0] v, input int l);
    return (n * MUX_RADIX + digit(v, l)) < NT;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l <= PIPE_DEPTH; l++) cnt_p[l] <= cnt_reset(l);
    end else if (en) begin
      cnt_p[0] <= (cnt_p[0] == AW'(NT - 1)) ? '0 : cnt_p[0] + 1'b1;
      for (int l = 1; l <= PIPE_DEPTH; l++) cnt_p[l] <= cnt_p[l-1];
    end
  end

  always_comb begin
    for (int i = 0; i < NT; i++) tbl[i] = AW'(tmx_pkg::rd_index(i, ROWS, COLS));
  end

  // Each tree level narrows the candidates by one radix digit of its count stage.
  for (genvar l = 0; l < PIPE_DEPTH; l++) begin : g_lvl
    logic [AW-1:0] q [NT];
    if (l == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int n = 0; n < NT; n++) q[n] <= '0;
        end else if (en) begin
          for (int n = 0; n < NT; n++)
            q[n] <= in_range(n, cnt_p[0], 0) ? tbl[pick(n, cnt_p[0], 0)] : '0;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int n = 0; n < NT; n++) q[n] <= '0;
        end else if (en) begin
          for (int n = 0; n < NT; n++)
            q[n] <= in_range(n, cnt_p[l], l) ? g_lvl[l-1].q[pick(n, cnt_p[l], l)] : '0;
        end
      end
    end
  end

  localparam int FSH = PIPE_DEPTH * SEL;

  logic [AW-1:0] last_idx;
  assign last_idx = cnt_p[PIPE_DEPTH] >> FSH;

  generate
    if (PIPE_DEPTH == 0) begin : g_flat
      assign rd_addr = tbl[last_idx];
    end else begin : g_tree
      assign rd_addr = g_lvl[PIPE_DEPTH-1].q[last_idx];
    end
  endgenerate

  assign wr_addr = cnt_p[PIPE_DEPTH];

endmodule

// File: rtl/tmx_store.sv
module tmx_store #(
  parameter int WL    = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] wr_addr,
  input  logic [WL-1:0] wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [WL-1:0] rdata
);

  logic [WL-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) mem[wr_addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (en) rdata <= mem[rd_addr];
  end

endmodule

// File: rtl/stream_transposer.sv
module stream_transposer #(
  parameter int WL         = 16,
  parameter int ROWS       = 4,
  parameter int COLS       = 8,
  parameter int IN_SYNC    = 1,
  parameter int MUX_RADIX  = 2,
  parameter int PIPE_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [WL-1:0] din,
  output logic [WL-1:0] dout
);

  localparam int NT = 2 * ROWS * COLS;
  localparam int AW = $clog2(NT);

  generate
    if (!((MUX_RADIX == 1 && PIPE_DEPTH == 0) ||
          (MUX_RADIX > 1 && tmx_pkg::is_pow2(MUX_RADIX) && PIPE_DEPTH >= 1 && IN_SYNC == 1)))
    begin : g_bad_cfg
      $error("stream_transposer: illegal radix/depth/input-register combination");
    end
    if (tmx_pkg::ipow(MUX_RADIX, PIPE_DEPTH) > NT) begin : g_bad_tree
      $error("stream_transposer: multiplexer tree wider than schedule period");
    end
  endgenerate

  logic [AW-1:0] wr_addr, rd_addr;
  logic [WL-1:0] wdata;

  tmx_delay #(.WL(WL), .STAGES(IN_SYNC + PIPE_DEPTH)) u_align (
    .clk(clk), .rst(rst), .en(en), .d(din), .q(wdata)
  );

  tmx_addr_gen #(
    .ROWS(ROWS), .COLS(COLS), .MUX_RADIX(MUX_RADIX),
    .PIPE_DEPTH(PIPE_DEPTH), .IN_SYNC(IN_SYNC)
  ) u_addr (
    .clk(clk), .rst(rst), .en(en), .wr_addr(wr_addr), .rd_addr(rd_addr)
  );

  tmx_store #(.WL(WL), .DEPTH(NT)) u_store (
    .clk(clk), .rst(rst), .en(en),
    .wr_addr(wr_addr), .wdata(wdata),
    .rd_addr(rd_addr), .rdata(dout)
  );

endmodule

// File: rtl/tmx_checker.sv
module tmx_checker #(
  parameter int NT     = 64,
  parameter int AW     = 6,
  parameter int WL     = 16,
  parameter int PIPE_D = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_addr,
  input logic [WL-1:0] dout
);

  localparam int HALF = NT / 2;

  int unsigned fill;
  always_ff @(posedge clk) begin
    if (rst) fill <= 0;
    else if (en && fill < PIPE_D) fill <= fill + 1;
  end

  logic primed;
  assign primed = (fill >= PIPE_D);

  AST_RESET_OUT: assert property (@(posedge clk) rst |=> (dout == '0)); // R1

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dout)); // R4

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(wr_addr)); // R4

  AST_WR_STEP: assert property (@(posedge clk) disable iff (rst)
    en |=> (wr_addr == (($past(wr_addr) == AW'(NT - 1)) ? '0 : $past(wr_addr) + 1'b1))); // R7

  AST_RD_RANGE: assert property (@(posedge clk) disable iff (rst)
    rd_addr < AW'(NT - 1) || rd_addr == AW'(NT - 1)); // R8

  AST_RD_BANK: assert property (@(posedge clk) disable iff (rst)
    primed |-> ((rd_addr >= AW'(HALF)) != (wr_addr >= AW'(HALF)))); // R8

endmodule

bind stream_transposer tmx_checker #(
  .NT(2 * ROWS * COLS), .AW($clog2(2 * ROWS * COLS)), .WL(WL), .PIPE_D(PIPE_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .en(en),
  .wr_addr(wr_addr), .rd_addr(rd_addr), .dout(dout)
);

// File: tb/stream_transposer_bench.sv
module stream_transposer_bench;

  localparam int NV = 5;
  localparam int RS [NV] = '{2, 3, 4, 5, 7};
  localparam int CS [NV] = '{2, 3, 4, 5, 7};
  localparam int MS [NV] = '{1, 2, 4, 4, 4};
  localparam int DS [NV] = '{0, 1, 1, 2, 3};
  localparam int IS [NV] = '{0, 1, 1, 1, 1};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] q_main;
  logic [15:0] q_v [NV];

  int checks = 0;
  int errors = 0;
  int n_done = 0;   // enabled edges since reset
  int t_in   = 0;   // next input word value

  always #4 clk = ~clk;   // 125 MHz

  stream_transposer #(
    .WL(16), .ROWS(4), .COLS(8), .IN_SYNC(1), .MUX_RADIX(2), .PIPE_DEPTH(2)
  ) u_stream_transposer (
    .clk(clk), .rst(rst), .en(en), .din(din), .dout(q_main)
  );

  for (genvar g = 0; g < NV; g++) begin : g_var
    stream_transposer #(
      .WL(16), .ROWS(RS[g]), .COLS(CS[g]), .IN_SYNC(IS[g]),
      .MUX_RADIX(MS[g]), .PIPE_DEPTH(DS[g])
    ) u_var (
      .clk(clk), .rst(rst), .en(en), .din(din), .dout(q_v[g])
    );
  end

  function automatic int expect_word(input int o, input int r, input int c);
    int n, b, j;
    n = r * c;
    b = o / n;
    j = o % n;
    return (b * n + (j % r) * c + j / r) & 16'hFFFF;
  endfunction

  task automatic check(input string req, input string who, input logic [15:0] act, input int exp);
    checks++;
    if (act !== exp[15:0]) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", req, who, act, exp, n_done);
    end
  endtask

  // Check every configuration whose latency has passed.
  task automatic check_all(input string req);
    int lat;
    lat = 32 + 2 + 1 + 1;
    if (n_done >= lat) check(req, "4x8 r2 d2", q_main, expect_word(n_done - lat, 4, 8));
    for (int g = 0; g < NV; g++) begin
      lat = RS[g] * CS[g] + DS[g] + IS[g] + 1;
      if (n_done >= lat)
        check(req, $sformatf("%0dx%0d r%0d d%0d", RS[g], CS[g], MS[g], DS[g]),
              q_v[g], expect_word(n_done - lat, RS[g], CS[g]));
    end
  endtask

  task automatic step(input bit e, input string req);
    @(negedge clk);
    en  = e;
    din = e ? t_in[15:0] : 16'hDEAD;
    @(posedge clk);
    @(negedge clk);
    if (e) begin
      n_done++;
      t_in++;
    end
    en = 1'b0;
    check_all(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b1;
    din = 16'h5A5A;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    en  = 1'b0;
    n_done = 0;
    t_in   = 0;
  endtask

  // R1: output cleared by reset
  task automatic test_reset();
    do_reset();
    check("R1", "4x8 r2 d2", q_main, 0);
    for (int g = 0; g < NV; g++) check("R1", $sformatf("cfg%0d", g), q_v[g], 0);
  endtask

  // R2 R3 R5 R6: four matrices of the largest shape, no pauses
  task automatic test_continuous();
    do_reset();
    for (int i = 0; i < 4 * 49 + 60; i++) step(1'b1, "R2/R3/R5/R6");
  endtask

  // R4: pauses with garbage on din
  task automatic test_pauses();
    logic [15:0] held;
    do_reset();
    for (int i = 0; i < 300; i++) begin
      if (i % 3 == 2 || (i > 100 && i < 106)) begin
        held = q_main;
        step(1'b0, "R4");
        check("R4", "4x8 hold", q_main, int'(held));
      end else begin
        step(1'b1, "R4");
      end
    end
  endtask

  // R1: reset in the middle of a stream restarts the schedule
  task automatic test_mid_reset();
    do_reset();
    for (int i = 0; i < 45; i++) step(1'b1, "R1");
    do_reset();
    check("R1", "4x8 mid-reset", q_main, 0);
    for (int i = 0; i < 2 * 49 + 60; i++) step(1'b1, "R1/R2");
  endtask

  initial begin
    test_reset();
    test_continuous();
    test_pauses();
    test_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule